// File: doc/BRIEF.md
# Reverse-Operand Subtract Execution Unit

This block executes one integer instruction of a 32-bit-word RISC format: a subtract whose result is the second source operand minus the first. Each cycle it may take an instruction word together with the two 64-bit operand values that the register file has already read. It checks that the word carries the right primary and extended opcodes. It produces the difference, the destination register index and a destination write strobe. It also keeps an overflow bit and a sticky summary-overflow bit, and it can write a four-bit condition field that compares the result with zero.

Two flag bits in the word decide which status state the instruction touches. When the overflow-enable flag is set, the overflow bit takes the signed overflow of the subtraction, and the summary bit gathers it. When the record flag is set, the condition field is written. A mode input selects whether overflow and the comparison use the full 64-bit value or only the low 32-bit word. An overflow is only recorded and never traps. Any other opcode gives a one-cycle illegal pulse and changes no state. All outputs are registered and appear one clock after the valid strobe.

Top module: `rsub_exec_unit`

## Requirements
- R1: An instruction is accepted when word bits [31:26] equal 31 and bits [9:1] equal 40. The destination index is taken from bits [25:21], the overflow-enable flag from bit 10 and the record flag from bit 0.
- R2: One cycle after an accepted valid instruction, `res_data` equals operand B minus operand A, modulo 2^64, and `dst_we` is 1. `res_data` and `dst_idx` keep their values when no accepted instruction arrives.
- R3: When the overflow-enable flag is 1, `ovf` becomes the signed overflow of B minus A and `ovf_we` pulses. When the flag is 0, `ovf` keeps its value.
- R4: `sum_ovf` is ORed with each new overflow value. Once set, it stays 1 until reset.
- R5: When the record flag is 1, `cond_we` pulses and `cond_fld` is written with [3]=less than zero, [2]=greater than zero and [1]=equal to zero, from a signed view of the result. Bit [0] is `sum_ovf` after this instruction's own update. Otherwise `cond_fld` keeps its value.
- R6: The two flags act independently. In each of the four flag combinations, only the state those flags name changes.
- R7: With `wide_mode`=1, overflow and the comparison use bit 63 and the full result. With `wide_mode`=0, overflow uses bit 31 and the comparison uses the sign-extended low 32 bits of the result.
- R8: For a valid word whose opcode does not match, `illegal` pulses one cycle later, `dst_we`, `ovf_we` and `cond_we` stay 0, and `ovf`, `sum_ovf`, `cond_fld` and `res_data` keep their values.
- R9: A synchronous active-high reset clears every output to 0.
- R10: `out_valid` follows `in_valid` with one cycle of latency. Without a valid strobe, no write strobe and no illegal pulse appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| opnd_a | input | 64 | Value of the first source register (subtrahend) |
| opnd_b | input | 64 | Value of the second source register (minuend) |
| wide_mode | input | 1 | 1: 64-bit overflow and compare; 0: 32-bit |
| out_valid | output | 1 | Registered copy of in_valid |
| illegal | output | 1 | Valid word with a non-matching opcode |
| dst_we | output | 1 | Destination write strobe |
| dst_idx | output | 5 | Destination register index |
| res_data | output | 64 | Difference B minus A |
| ovf_we | output | 1 | Overflow and summary were updated |
| ovf | output | 1 | Overflow status bit |
| sum_ovf | output | 1 | Sticky summary-overflow bit |
| cond_we | output | 1 | Condition field was written |
| cond_fld | output | 4 | Condition field {lt, gt, eq, summary} |

## Verification
The assertions check on every cycle that an illegal pulse never comes with a write strobe and that the summary bit never falls without reset. They also check that overflow holds when it is not updated, that a written condition field has exactly one of its three compare bits set, and that its low bit matches the summary bit. The result arithmetic, the operand order, the overflow bit position in each mode and the exact compare outcome at the boundaries (the most negative values, zero, equal operands) can only be shown by the bench. The bench compares every output against its model on every clock.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned PRI_W     = 6;
  localparam int unsigned EXT_W     = 9;
  localparam logic [PRI_W-1:0] PRI_CODE = 6'd31;
  localparam logic [EXT_W-1:0] EXT_CODE = 9'd40;

  typedef struct packed {
    logic                 match;
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src_a;
    logic [REG_IDX_W-1:0] src_b;
    logic                 ovf_en;
    logic                 rec_en;
  } rsub_dec_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } rsub_cond_t;
endpackage

// File: rtl/rsub_decode.sv
module rsub_decode
  import rsub_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output rsub_dec_t          dec
);
  // Field positions: bit 0 of the big-endian numbering is bit INSTR_W-1 here
  localparam int unsigned PRI_LSB = INSTR_W - PRI_W;
  localparam int unsigned DST_LSB = PRI_LSB - REG_IDX_W;
  localparam int unsigned SA_LSB  = DST_LSB - REG_IDX_W;
  localparam int unsigned SB_LSB  = SA_LSB - REG_IDX_W;
  localparam int unsigned OE_POS  = SB_LSB - 1;
  localparam int unsigned EXT_LSB = 1;
  localparam int unsigned REC_POS = 0;

  always_comb begin
    dec.match  = (instr[PRI_LSB +: PRI_W] == PRI_CODE) &&
                 (instr[EXT_LSB +: EXT_W] == EXT_CODE);
    dec.dst    = instr[DST_LSB +: REG_IDX_W];
    dec.src_a  = instr[SA_LSB +: REG_IDX_W];
    dec.src_b  = instr[SB_LSB +: REG_IDX_W];
    dec.ovf_en = instr[OE_POS];
    dec.rec_en = instr[REC_POS];
  end
endmodule

// File: rtl/rsub_alu.sv
module rsub_alu #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              wide_mode,
  output logic [DATA_W-1:0] diff,
  output logic              ovf,
  output logic              lt,
  output logic              gt,
  output logic              eq
);
  localparam int unsigned EXT_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] ovf_vec;
  logic [DATA_W-1:0] narrow_view;
  logic [DATA_W-1:0] cmp_val;

  // complement-and-add form of b - a
  assign diff    = (~opnd_a) + opnd_b + {{(DATA_W-1){1'b0}}, 1'b1};
  assign ovf_vec = (opnd_a ^ opnd_b) & (opnd_b ^ diff);

  generate
    if (EXT_W > 0) begin : g_sext
      assign narrow_view = {{EXT_W{diff[NARROW_W-1]}}, diff[NARROW_W-1:0]};
    end else begin : g_same
      assign narrow_view = diff;
    end
  endgenerate

  always_comb begin
    ovf     = wide_mode ? ovf_vec[DATA_W-1] : ovf_vec[NARROW_W-1];
    cmp_val = wide_mode ? diff : narrow_view;
    lt      = cmp_val[DATA_W-1];
    eq      = (cmp_val == '0);
    gt      = !lt && !eq;
  end
endmodule

// File: rtl/rsub_status.sv
module rsub_status (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic ovf_new,
  output logic ovf_q,
  output logic so_q,
  output logic so_next
);
  assign so_next = upd ? (so_q | ovf_new) : so_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      so_q  <= 1'b0;
    end else if (upd) begin
      ovf_q <= ovf_new;
      so_q  <= so_next;
    end
  end

  AST_SUM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(so_q)) |-> so_q); // R4
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ovf_q)); // R3
endmodule

// File: rtl/rsub_exec_unit.sv
module rsub_exec_unit
  import rsub_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    opnd_a,
  input  logic [DATA_W-1:0]    opnd_b,
  input  logic                 wide_mode,
  output logic                 out_valid,
  output logic                 illegal,
  output logic                 dst_we,
  output logic [REG_IDX_W-1:0] dst_idx,
  output logic [DATA_W-1:0]    res_data,
  output logic                 ovf_we,
  output logic                 ovf,
  output logic                 sum_ovf,
  output logic                 cond_we,
  output logic [3:0]           cond_fld
);
  rsub_dec_t         dec;
  logic [DATA_W-1:0] diff;
  logic              ovf_c, lt_c, gt_c, eq_c;
  logic              accept, ovf_upd, cond_upd, so_next;
  rsub_cond_t        cond_c;

  rsub_decode u_dec (.instr(instr), .dec(dec));

  rsub_alu #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_alu (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .wide_mode(wide_mode),
    .diff(diff), .ovf(ovf_c), .lt(lt_c), .gt(gt_c), .eq(eq_c)
  );

  assign accept   = in_valid && dec.match;
  assign ovf_upd  = accept && dec.ovf_en;
  assign cond_upd = accept && dec.rec_en;

  rsub_status u_stat (
    .clk(clk), .rst(rst), .upd(ovf_upd), .ovf_new(ovf_c),
    .ovf_q(ovf), .so_q(sum_ovf), .so_next(so_next)
  );

  always_comb begin
    cond_c.lt = lt_c;
    cond_c.gt = gt_c;
    cond_c.eq = eq_c;
    cond_c.so = so_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      dst_we    <= 1'b0;
      ovf_we    <= 1'b0;
      cond_we   <= 1'b0;
      dst_idx   <= '0;
      res_data  <= '0;
      cond_fld  <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && !dec.match;
      dst_we    <= accept;
      ovf_we    <= ovf_upd;
      cond_we   <= cond_upd;
      if (accept) begin
        dst_idx  <= dec.dst;
        res_data <= diff;
      end
      if (cond_upd) cond_fld <= cond_c;
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !(dst_we || ovf_we || cond_we)); // R8
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(dst_we || illegal)); // R10
  AST_COND_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    cond_we |-> ($countones(cond_fld[3:1]) == 1)); // R5
  AST_COND_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    cond_we |-> (cond_fld[0] == sum_ovf)); // R5
  AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cond_upd |=> $stable(cond_fld)); // R6
endmodule

// File: tb/rsub_exec_unit_bench.sv
module rsub_exec_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic wide_mode = 1'b1;
  logic out_valid, illegal, dst_we, ovf_we, ovf, sum_ovf, cond_we;
  logic [4:0] dst_idx;
  logic [63:0] res_data;
  logic [3:0] cond_fld;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  logic e_valid, e_ill, e_dwe, e_owe, e_ov, e_so, e_cwe;
  logic [4:0] e_idx;
  logic [63:0] e_res;
  logic [3:0] e_cond;

  always #10 clk = ~clk;

  rsub_exec_unit u_rsub_exec_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .wide_mode(wide_mode),
    .out_valid(out_valid), .illegal(illegal), .dst_we(dst_we),
    .dst_idx(dst_idx), .res_data(res_data), .ovf_we(ovf_we), .ovf(ovf),
    .sum_ovf(sum_ovf), .cond_we(cond_we), .cond_fld(cond_fld)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int rd, bit oe, bit rc);
    return {6'd31, rd[4:0], 5'd3, 5'd4, oe, 9'd40, rc};
  endfunction

  task automatic model_reset();
    e_valid = 0; e_ill = 0; e_dwe = 0; e_owe = 0; e_ov = 0; e_so = 0;
    e_cwe = 0; e_idx = '0; e_res = '0; e_cond = '0;
  endtask

  task automatic model_step(bit v, logic [31:0] w, logic [63:0] a, logic [63:0] b, bit wm);
    bit hit;
    longint sa, sb, r;
    logic signed [64:0] wide_d;
    logic signed [32:0] nar_d;
    bit o;
    e_valid = v;
    hit = (w[31:26] == 6'd31) && (w[9:1] == 9'd40);
    e_ill = v && !hit;
    e_dwe = v && hit;
    e_owe = v && hit && w[10];
    e_cwe = v && hit && w[0];
    if (v && hit) begin
      e_res = b - a;
      e_idx = w[25:21];
      if (w[10]) begin
        if (wm) begin
          wide_d = $signed({b[63], b}) - $signed({a[63], a});
          o = (wide_d > 65'sh0_7FFF_FFFF_FFFF_FFFF) || (wide_d < -65'sh0_8000_0000_0000_0000);
        end else begin
          nar_d = $signed({b[31], b[31:0]}) - $signed({a[31], a[31:0]});
          o = (nar_d > 33'sh0_7FFF_FFFF) || (nar_d < -33'sh0_8000_0000);
        end
        e_ov = o;
        e_so = e_so | o;
      end
      if (w[0]) begin
        r = wm ? longint'(e_res) : longint'(int'(e_res[31:0]));
        e_cond = {r < 0, r > 0, r == 0, e_so};
      end
    end
  endtask

  task automatic compare_all();
    chk("R10", "out_valid", 64'(out_valid), 64'(e_valid));
    chk("R8", "illegal", 64'(illegal), 64'(e_ill));
    chk("R2", "dst_we", 64'(dst_we), 64'(e_dwe));
    chk("R2", "res_data", res_data, e_res);
    chk("R1", "dst_idx", 64'(dst_idx), 64'(e_idx));
    chk("R3", "ovf_we", 64'(ovf_we), 64'(e_owe));
    chk("R3", "ovf", 64'(ovf), 64'(e_ov));
    chk("R4", "sum_ovf", 64'(sum_ovf), 64'(e_so));
    chk("R5", "cond_we", 64'(cond_we), 64'(e_cwe));
    chk("R5", "cond_fld", 64'(cond_fld), 64'(e_cond));
  endtask

  task automatic cyc(bit v, logic [31:0] w, logic [63:0] a, logic [63:0] b, bit wm);
    in_valid = v; instr = w; opnd_a = a; opnd_b = b; wide_mode = wm;
    model_step(v, w, a, b, wm);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: outputs cleared by reset
    compare_all();
    chk("R9", "reset res", res_data, 64'd0);
    // R2/R1 plain subtract, operand order 10 - 3
    cyc(1, mk(7, 0, 0), 64'd3, 64'd10, 1);
    chk("R2", "order b-a", res_data, 64'd7);
    // R6: record only, negative result
    cyc(1, mk(2, 0, 1), 64'd10, 64'd3, 1);
    chk("R5", "neg lt", 64'(cond_fld), 64'b1000);
    // R3 R7: wide overflow min - 1
    cyc(1, mk(1, 1, 0), 64'd1, 64'h8000_0000_0000_0000, 1);
    chk("R3", "wide ovf", 64'(ovf), 64'd1);
    // R6: overflow flag clear leaves ovf held
    cyc(1, mk(1, 0, 0), 64'd0, 64'd0, 1);
    chk("R6", "ovf held", 64'(ovf), 64'd1);
    // R4: non-overflowing update clears ovf, summary stays
    cyc(1, mk(4, 1, 1), 64'd5, 64'd5, 1);
    chk("R4", "sticky", 64'(sum_ovf), 64'd1);
    chk("R5", "eq with so", 64'(cond_fld), 64'b0011);
    // R8: wrong primary, wrong extended opcode
    cyc(1, {6'd30, 20'h12345, 6'd0}, 64'd1, 64'd9, 1);
    cyc(1, {6'd31, 5'd9, 5'd1, 5'd2, 1'b1, 9'd41, 1'b1}, 64'd1, 64'd9, 1);
    chk("R8", "illegal held res", res_data, 64'd0);
    // reset to clear sticky
    rst = 1; model_reset(); in_valid = 0;
    @(negedge clk); rst = 0; @(negedge clk);
    compare_all();
    // R7: narrow mode overflow at bit 31 and sign-extended compare
    cyc(1, mk(5, 1, 1), 64'd1, 64'h0000_0000_8000_0000, 0);
    chk("R7", "narrow ovf", 64'(ovf), 64'd1);
    chk("R7", "narrow gt", 64'(cond_fld), 64'b0101);
    cyc(1, mk(5, 1, 1), 64'd0, 64'hFFFF_FFFF_0000_0000, 0);
    chk("R7", "narrow eq", 64'(cond_fld), 64'b0011);
    // R10: idle cycles
    cyc(0, mk(3, 1, 1), 64'd9, 64'd1, 1);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      logic [63:0] a, b;
      w = mk($urandom_range(0, 31), $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) w[$urandom_range(0, 31)] ^= 1'b1;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b = a;
      if ($urandom_range(0, 5) == 0) a = {$urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'h0, $urandom};
      cyc($urandom_range(0, 4) != 0, w, a, b, $urandom_range(0, 1));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule